// File: doc/BRIEF.md
# Control-Flow Sequencer for an 8-bit Accumulator Core

This block runs the program-counter and stack side of an 8-bit accumulator instruction set. The surrounding core has already fetched an opcode. It presents that opcode on `opcode` with a one-cycle `start` pulse, together with the current flag byte, the accumulator and the HL pair. The sequencer holds PC and SP. It fetches any immediate bytes itself and performs stack pushes and pops through a byte-wide memory port. That port carries one request at a time and a ready handshake. Register results come back as single-cycle write strobes in the cycle that `done` is high. Opcodes that are not control-flow finish at once and change nothing.

The control-flow instructions it executes are:
- unconditional and conditional jumps, calls and returns;
- the eight restart vectors;
- loading PC from HL, and exchanging HL with the top of the stack;
- pushing and popping the accumulator-plus-flags word;
- halt;
- a two-byte escape opcode (0xED). Its second byte selects one of three actions: a software interrupt, an exit to native mode, or a call to an address given in the instruction stream.

The controller is a single state machine with these states: IDLE, IMM_LO, IMM_HI, ESC_SEL, ESC_ARG, PUSH_HI, PUSH_LO, POP_LO, POP_HI, DONE and HALT. Its transitions are:
- IDLE moves on `start` to the first phase the opcode needs. Immediate-carrying ops go to IMM_LO. Returns, XTHL and flag-word pops go to POP_LO. Restarts and flag-word pushes go to PUSH_HI. The escape opcode goes to ESC_SEL. Everything else goes to DONE.
- IMM_LO goes to IMM_HI. IMM_HI goes to PUSH_HI for a call that is taken, otherwise to DONE.
- ESC_SEL goes to ESC_ARG, POP_LO or IMM_HI, depending on the selector byte. ESC_ARG goes to DONE.
- PUSH_HI goes to PUSH_LO, and PUSH_LO goes to DONE.
- POP_LO goes to POP_HI. POP_HI goes back to POP_LO while the native-mode exit still has words to pop, to PUSH_HI for XTHL, and otherwise to DONE.
- DONE goes to HALT after a halt instruction, otherwise to IDLE.
- HALT goes to IDLE on `irq`.

Every memory state waits there until `mem_rdy`.

Top module: `flowseq_core`

## Requirements
- R1: After reset PC equals PC_RESET, SP equals SP_RESET, `busy`, `halted`, `native_mode` and `mem_req` are low.
- R2: For conditional jumps, calls and returns, opcode bits 5:3 pick the test. The eight codes 0 to 7 mean not-zero, zero, no-carry, carry, parity-odd, parity-even, plus and minus. The tests read `flags_in` bit 6 (zero), bit 0 (carry), bit 2 (parity) and bit 7 (sign).
- R3: JMP (0xC3) and conditional jumps (11ccc010) always read two immediate bytes, low byte at PC first, then the high byte at PC+1. When taken, PC becomes the immediate; otherwise PC advances by 2.
- R4: CALL (0xCD) and conditional calls (11ccc100) always read the two immediate bytes. When taken, the address after the immediates is pushed and PC loads the immediate. When not taken, PC advances by 2 and no write occurs.
- R5: RET (0xC9) and conditional returns (11ccc000) pop PC when taken. When not taken, they leave PC and SP unchanged and issue no memory request.
- R6: RST n (11nnn111) pushes the current PC and sets PC to 8*n.
- R7: PCHL (0xE9) copies `hl_in` into PC. XTHL (0xE3) returns the old top-of-stack word on `hl_wdata` with `hl_we`, writes the old HL into the stack slot, and leaves SP unchanged.
- R8: A push writes the high byte at SP-1 and then the low byte at SP-2, and SP drops by 2. A pop reads the low byte at SP and the high byte at SP+1, and SP rises by 2. SP never moves by any other amount in one cycle.
- R9: Flag-word push (0xF5) stores `acc_in` as the high byte and `flags_in` as the low byte. Flag-word pop (0xF1) returns the high byte on `acc_wdata` and the low byte on `flag_wdata[7:0]`, with `acc_we` and `flag_lo_we`; `flag_all_we` stays low. These strobes appear only while `done` is high.
- R10: HLT (0x76) completes with `done`, then `halted` rises. While halted, `start` is ignored and no memory request is made. `irq` clears `halted`.
- R11: Escape 0xED followed by 0xED and a byte v raises `swi_req` for one cycle with `swi_vec` = v at `done`. PC advances past both bytes and SP is unchanged.
- R12: Escape 0xED followed by 0xFD pops three words in order into PC, `seg_out` and `flag_wdata` (with `flag_all_we`), and sets `native_mode`. SP rises by 6, and `native_mode` rises in the `done` cycle.
- R13: Escape 0xED followed by any other byte b and then a byte h pushes the address after h and sets PC to {h,b}.
- R14: `busy` is high from the cycle after `start` until `done`, and `done` lasts one cycle. A memory request holds its address and direction until `mem_rdy`. A non-control-flow opcode finishes with no memory request and no change to PC or SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `opcode` (sampled in IDLE) |
| opcode | input | 8 | Already-fetched opcode |
| flags_in | input | 8 | Current flag byte (S=7, Z=6, P=2, C=0) |
| acc_in | input | 8 | Current accumulator |
| hl_in | input | 16 | Current HL pair |
| irq | input | 1 | Interrupt request, wakes from halt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_rdy` |
| mem_rdy | input | 1 | Request completes this cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished (one cycle) |
| halted | output | 1 | Halt state |
| hl_we | output | 1 | Write `hl_wdata` to HL |
| hl_wdata | output | 16 | New HL value |
| acc_we | output | 1 | Write `acc_wdata` to accumulator |
| acc_wdata | output | 8 | New accumulator value |
| flag_lo_we | output | 1 | Replace low flag byte with `flag_wdata[7:0]` |
| flag_all_we | output | 1 | Replace whole flag word |
| flag_wdata | output | 16 | New flag value |
| seg_out | output | 16 | Code segment popped on native exit |
| native_mode | output | 1 | Native-mode flag |
| swi_req | output | 1 | Software interrupt request (one cycle) |
| swi_vec | output | 8 | Software interrupt vector |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a pending request holds its address and direction, that `done` lasts one cycle, that no request is made while idle or halted, and that halt persists without `irq`. It also checks that SP only ever steps by two, that result strobes appear only with `done`, and that `native_mode` rises only at completion. What values land where can only be shown by the bench scenarios: the taken and not-taken outcome of each condition code, the return address bytes on the stack, the restart targets, the XTHL exchange and the three escape behaviours.

// File: rtl/flowseq_pkg.sv
package flowseq_pkg;

    typedef enum logic [3:0] {
        CL_OTHER, CL_JMP, CL_JCC, CL_CALL, CL_CCC, CL_RET, CL_RCC,
        CL_RST, CL_PCHL, CL_XTHL, CL_PUSHPSW, CL_POPPSW, CL_HALT, CL_ESC
    } op_class_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_IMM_LO, ST_IMM_HI, ST_ESC_SEL, ST_ESC_ARG,
        ST_PUSH_HI, ST_PUSH_LO, ST_POP_LO, ST_POP_HI, ST_DONE, ST_HALT
    } fsm_state_t;

    // flag byte positions tested by conditions
    localparam int FLAG_C = 0;
    localparam int FLAG_P = 2;
    localparam int FLAG_Z = 6;
    localparam int FLAG_S = 7;

    // fixed opcodes
    localparam logic [7:0] OPC_JMP  = 8'hC3;
    localparam logic [7:0] OPC_CALL = 8'hCD;
    localparam logic [7:0] OPC_RET  = 8'hC9;
    localparam logic [7:0] OPC_PCHL = 8'hE9;
    localparam logic [7:0] OPC_XTHL = 8'hE3;
    localparam logic [7:0] OPC_PSHW = 8'hF5;
    localparam logic [7:0] OPC_POPW = 8'hF1;
    localparam logic [7:0] OPC_HALT = 8'h76;
    localparam logic [7:0] OPC_ESC  = 8'hED;

    // escape selector bytes
    localparam logic [7:0] ESC_SWI    = 8'hED;
    localparam logic [7:0] ESC_NATIVE = 8'hFD;

endpackage

// File: rtl/flowseq_decode.sv
module flowseq_decode
    import flowseq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_class_t  cls,
    output logic [2:0] sel
);
    assign sel = opcode[5:3];

    always_comb begin
        cls = CL_OTHER;
        if (opcode[7:6] == 2'b11) begin
            unique case (opcode[2:0])
                3'b000:  cls = CL_RCC;
                3'b010:  cls = CL_JCC;
                3'b100:  cls = CL_CCC;
                3'b111:  cls = CL_RST;
                default: cls = CL_OTHER;
            endcase
            unique case (opcode)
                OPC_JMP:  cls = CL_JMP;
                OPC_CALL: cls = CL_CALL;
                OPC_RET:  cls = CL_RET;
                OPC_PCHL: cls = CL_PCHL;
                OPC_XTHL: cls = CL_XTHL;
                OPC_PSHW: cls = CL_PUSHPSW;
                OPC_POPW: cls = CL_POPPSW;
                OPC_ESC:  cls = CL_ESC;
                default:  ;
            endcase
        end
        if (opcode == OPC_HALT)
            cls = CL_HALT;
    end
endmodule

// File: rtl/flowseq_cond.sv
module flowseq_cond (
    input  logic [3:0] tests,   // {sign, parity, carry, zero}
    input  logic [2:0] sel,
    output logic       take
);
    logic bit_val;
    assign bit_val = tests[sel[2:1]];
    assign take    = sel[0] ? bit_val : ~bit_val;
endmodule

// File: rtl/flowseq_core.sv
module flowseq_core
    import flowseq_pkg::*;
#(
    parameter int              BW         = 8,
    parameter logic [2*BW-1:0] PC_RESET   = '0,
    parameter logic [2*BW-1:0] SP_RESET   = '0,
    parameter int              RST_STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [BW-1:0] flags_in,
    input  logic [BW-1:0] acc_in,
    input  logic [2*BW-1:0] hl_in,
    input  logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [2*BW-1:0] mem_addr,
    output logic [BW-1:0] mem_wdata,
    input  logic [BW-1:0] mem_rdata,
    input  logic          mem_rdy,
    output logic [2*BW-1:0] pc,
    output logic [2*BW-1:0] sp,
    output logic          busy,
    output logic          done,
    output logic          halted,
    output logic          hl_we,
    output logic [2*BW-1:0] hl_wdata,
    output logic          acc_we,
    output logic [BW-1:0] acc_wdata,
    output logic          flag_lo_we,
    output logic          flag_all_we,
    output logic [2*BW-1:0] flag_wdata,
    output logic [2*BW-1:0] seg_out,
    output logic          native_mode,
    output logic          swi_req,
    output logic [BW-1:0] swi_vec
);
    localparam int          AW      = 2 * BW;
    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP2 = AW'(2);
    localparam logic [1:0]  LAST_POP = 2'd2;

    fsm_state_t st, st_n;
    op_class_t  cls_in, cls_q;
    logic [2:0] sel_in;
    logic       take_in, take_q;

    logic [AW-1:0] pc_q, sp_q, wbuf_q, rbuf_q, seg_q;
    logic [BW-1:0] tgt_lo_q, vec_q;
    logic [1:0]    pops_q;
    logic          esc_exit_q;
    logic          p_hl, p_psw, p_fall, p_swi, p_halt, native_q;
    logic          fire;
    logic          call_go;
    logic [AW-1:0] pop_word;

    flowseq_decode u_dec (
        .opcode (opcode),
        .cls    (cls_in),
        .sel    (sel_in)
    );

    flowseq_cond u_cond (
        .tests ({flags_in[FLAG_S], flags_in[FLAG_P], flags_in[FLAG_C], flags_in[FLAG_Z]}),
        .sel   (sel_in),
        .take  (take_in)
    );

    assign fire     = mem_req & mem_rdy;
    assign call_go  = (cls_q == CL_CALL) || (cls_q == CL_ESC) || ((cls_q == CL_CCC) && take_q);
    assign pop_word = {mem_rdata, rbuf_q[BW-1:0]};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (start) begin
                unique case (cls_in)
                    CL_JMP, CL_JCC, CL_CALL, CL_CCC:  st_n = ST_IMM_LO;
                    CL_RET, CL_XTHL, CL_POPPSW:       st_n = ST_POP_LO;
                    CL_RCC:                           st_n = take_in ? ST_POP_LO : ST_DONE;
                    CL_RST, CL_PUSHPSW:               st_n = ST_PUSH_HI;
                    CL_ESC:                           st_n = ST_ESC_SEL;
                    default:                          st_n = ST_DONE;
                endcase
            end
            ST_IMM_LO:  if (fire) st_n = ST_IMM_HI;
            ST_IMM_HI:  if (fire) st_n = call_go ? ST_PUSH_HI : ST_DONE;
            ST_ESC_SEL: if (fire) begin
                if (mem_rdata == BW'(ESC_SWI))         st_n = ST_ESC_ARG;
                else if (mem_rdata == BW'(ESC_NATIVE)) st_n = ST_POP_LO;
                else                                   st_n = ST_IMM_HI;
            end
            ST_ESC_ARG: if (fire) st_n = ST_DONE;
            ST_PUSH_HI: if (fire) st_n = ST_PUSH_LO;
            ST_PUSH_LO: if (fire) st_n = ST_DONE;
            ST_POP_LO:  if (fire) st_n = ST_POP_HI;
            ST_POP_HI:  if (fire) begin
                if (cls_q == CL_XTHL)                     st_n = ST_PUSH_HI;
                else if (esc_exit_q && pops_q != LAST_POP) st_n = ST_POP_LO;
                else                                      st_n = ST_DONE;
            end
            ST_DONE:    st_n = p_halt ? ST_HALT : ST_IDLE;
            ST_HALT:    if (irq) st_n = ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= PC_RESET;
            sp_q       <= SP_RESET;
            cls_q      <= CL_OTHER;
            take_q     <= 1'b0;
            wbuf_q     <= '0;
            rbuf_q     <= '0;
            seg_q      <= '0;
            tgt_lo_q   <= '0;
            vec_q      <= '0;
            pops_q     <= '0;
            esc_exit_q <= 1'b0;
            p_hl       <= 1'b0;
            p_psw      <= 1'b0;
            p_fall     <= 1'b0;
            p_swi      <= 1'b0;
            p_halt     <= 1'b0;
            native_q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    cls_q      <= cls_in;
                    take_q     <= take_in;
                    pops_q     <= '0;
                    esc_exit_q <= 1'b0;
                    p_hl       <= 1'b0;
                    p_psw      <= 1'b0;
                    p_fall     <= 1'b0;
                    p_swi      <= 1'b0;
                    p_halt     <= (cls_in == CL_HALT);
                    if (cls_in == CL_RST) begin
                        wbuf_q <= pc_q;
                        pc_q   <= AW'(sel_in) * AW'(RST_STRIDE);
                    end
                    if (cls_in == CL_PUSHPSW) wbuf_q <= {acc_in, flags_in};
                    if (cls_in == CL_PCHL)    pc_q   <= hl_in;
                end
                ST_IMM_LO: if (fire) begin
                    tgt_lo_q <= mem_rdata;
                    pc_q     <= pc_q + STEP1;
                end
                ST_IMM_HI: if (fire) begin
                    if ((cls_q == CL_JMP) || ((cls_q == CL_JCC) && take_q)) begin
                        pc_q <= {mem_rdata, tgt_lo_q};
                    end else if (call_go) begin
                        wbuf_q <= pc_q + STEP1;
                        pc_q   <= {mem_rdata, tgt_lo_q};
                    end else begin
                        pc_q <= pc_q + STEP1;
                    end
                end
                ST_ESC_SEL: if (fire) begin
                    pc_q       <= pc_q + STEP1;
                    tgt_lo_q   <= mem_rdata;
                    esc_exit_q <= (mem_rdata == BW'(ESC_NATIVE));
                end
                ST_ESC_ARG: if (fire) begin
                    pc_q  <= pc_q + STEP1;
                    vec_q <= mem_rdata;
                    p_swi <= 1'b1;
                end
                ST_PUSH_LO: if (fire) sp_q <= sp_q - STEP2;
                ST_POP_LO:  if (fire) rbuf_q[BW-1:0] <= mem_rdata;
                ST_POP_HI:  if (fire) begin
                    rbuf_q[AW-1:BW] <= mem_rdata;
                    sp_q            <= sp_q + STEP2;
                    unique case (cls_q)
                        CL_RET, CL_RCC: pc_q <= pop_word;
                        CL_POPPSW:      p_psw <= 1'b1;
                        CL_XTHL: begin
                            wbuf_q <= hl_in;
                            p_hl   <= 1'b1;
                        end
                        CL_ESC: begin
                            pops_q <= pops_q + 2'd1;
                            unique case (pops_q)
                                2'd0:    pc_q  <= pop_word;
                                2'd1:    seg_q <= pop_word;
                                default: begin
                                    native_q <= 1'b1;
                                    p_fall   <= 1'b1;
                                end
                            endcase
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = '0;
        unique case (st)
            ST_IMM_LO, ST_IMM_HI, ST_ESC_SEL, ST_ESC_ARG: begin
                mem_req  = 1'b1;
                mem_addr = pc_q;
            end
            ST_PUSH_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - STEP1;
                mem_wdata = wbuf_q[AW-1:BW];
            end
            ST_PUSH_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - STEP2;
                mem_wdata = wbuf_q[BW-1:0];
            end
            ST_POP_LO: begin
                mem_req  = 1'b1;
                mem_addr = sp_q;
            end
            ST_POP_HI: begin
                mem_req  = 1'b1;
                mem_addr = sp_q + STEP1;
            end
            default: ;
        endcase
    end

    assign pc          = pc_q;
    assign sp          = sp_q;
    assign busy        = (st != ST_IDLE) && (st != ST_HALT);
    assign done        = (st == ST_DONE);
    assign halted      = (st == ST_HALT);
    assign hl_we       = done & p_hl;
    assign hl_wdata    = rbuf_q;
    assign acc_we      = done & p_psw;
    assign acc_wdata   = rbuf_q[AW-1:BW];
    assign flag_lo_we  = done & p_psw;
    assign flag_all_we = done & p_fall;
    assign flag_wdata  = rbuf_q;
    assign seg_out     = seg_q;
    assign native_mode = native_q;
    assign swi_req     = done & p_swi;
    assign swi_vec     = vec_q;
endmodule

// File: rtl/flowseq_checker.sv
module flowseq_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rdy,
    input logic [AW-1:0] sp,
    input logic          busy,
    input logic          done,
    input logic          halted,
    input logic          hl_we,
    input logic          acc_we,
    input logic          swi_req,
    input logic          native_mode
);
    assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !busy));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !irq) |=> halted);

    assert_sp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> ((sp - $past(sp)) == AW'(2) || ($past(sp) - sp) == AW'(2)));

    assert_native_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(native_mode) |-> done);

    assert_strobe_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_we || acc_we || swi_req) |-> done);
endmodule

bind flowseq_core flowseq_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_rdy     (mem_rdy),
    .sp          (sp),
    .busy        (busy),
    .done        (done),
    .halted      (halted),
    .hl_we       (hl_we),
    .acc_we      (acc_we),
    .swi_req     (swi_req),
    .native_mode (native_mode)
);

// File: tb/sim_flowseq_core.sv
module sim_flowseq_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  flags_in = '0;
    logic [7:0]  acc_in = '0;
    logic [15:0] hl_in = '0;
    logic        irq = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic [15:0] pc, sp, hl_wdata, flag_wdata, seg_out;
    logic        busy, done, halted, hl_we, acc_we, flag_lo_we, flag_all_we, native_mode, swi_req;
    logic [7:0]  acc_wdata, swi_vec;

    flowseq_core #(.PC_RESET(16'h0100), .SP_RESET(16'h0300)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .flags_in(flags_in),
        .acc_in(acc_in), .hl_in(hl_in), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .pc(pc), .sp(sp), .busy(busy), .done(done), .halted(halted), .hl_we(hl_we),
        .hl_wdata(hl_wdata), .acc_we(acc_we), .acc_wdata(acc_wdata), .flag_lo_we(flag_lo_we),
        .flag_all_we(flag_all_we), .flag_wdata(flag_wdata), .seg_out(seg_out),
        .native_mode(native_mode), .swi_req(swi_req), .swi_vec(swi_vec)
    );

    // memory model: answers every request one cycle later
    logic [7:0] mem [0:1023];
    int n_txn = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rdy <= 1'b0;
        end else begin
            mem_rdy <= 1'b0;
            if (mem_req && !mem_rdy) begin
                mem_rdy   <= 1'b1;
                mem_rdata <= mem[mem_addr[9:0]];
                if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
                n_txn <= n_txn + 1;
            end
        end
    end

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] v);
        mem[a[9:0]] <= v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; irq = 1'b0;
        poke(16'h0100, 8'h34); poke(16'h0101, 8'h02);
        poke(16'h0300, 8'h78); poke(16'h0301, 8'h05);
        poke(16'h02FE, 8'h00); poke(16'h02FF, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] fl);
        opcode = op; flags_in = fl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 64 && !done; k++) @(negedge clk);
        if (!done) chk("R14 done timeout", 32'd0, 32'd1);
    endtask

    function automatic string tag_of(input logic [7:0] op);
        if (op[2:1] == 2'b00) return "R5";
        if (op[2:1] == 2'b01) return "R3";
        return "R4";
    endfunction

    // {opcode, flags, expected pc, expected sp}; target 0x0234, stacked word 0x0578 (R2 codes)
    localparam int NV = 24;
    localparam logic [47:0] VEC [0:NV-1] = '{
        {8'hC3, 8'h00, 16'h0234, 16'h0300},
        {8'hC2, 8'h00, 16'h0234, 16'h0300},
        {8'hC2, 8'h40, 16'h0102, 16'h0300},
        {8'hCA, 8'h40, 16'h0234, 16'h0300},
        {8'hCA, 8'h00, 16'h0102, 16'h0300},
        {8'hD2, 8'h00, 16'h0234, 16'h0300},
        {8'hDA, 8'h01, 16'h0234, 16'h0300},
        {8'hDA, 8'h00, 16'h0102, 16'h0300},
        {8'hE2, 8'h00, 16'h0234, 16'h0300},
        {8'hEA, 8'h04, 16'h0234, 16'h0300},
        {8'hEA, 8'h00, 16'h0102, 16'h0300},
        {8'hF2, 8'h80, 16'h0102, 16'h0300},
        {8'hFA, 8'h80, 16'h0234, 16'h0300},
        {8'hCD, 8'h00, 16'h0234, 16'h02FE},
        {8'hC4, 8'h40, 16'h0102, 16'h0300},
        {8'hCC, 8'h40, 16'h0234, 16'h02FE},
        {8'hDC, 8'h01, 16'h0234, 16'h02FE},
        {8'hD4, 8'h01, 16'h0102, 16'h0300},
        {8'hF4, 8'h00, 16'h0234, 16'h02FE},
        {8'hC9, 8'h00, 16'h0578, 16'h0302},
        {8'hC0, 8'h40, 16'h0100, 16'h0300},
        {8'hD0, 8'h00, 16'h0578, 16'h0302},
        {8'hE8, 8'h00, 16'h0100, 16'h0300},
        {8'hF8, 8'h80, 16'h0578, 16'h0302}
    };

    initial begin
        int t0;
        // R1 reset state
        do_reset();
        chk("R1 pc", 32'(pc), 32'h0100);
        chk("R1 sp", 32'(sp), 32'h0300);
        chk("R1 busy/halted/native/req", {28'd0, busy, halted, native_mode, mem_req}, 32'd0);

        // R2-R5 table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            t0 = n_txn;
            run_op(VEC[i][47:40], VEC[i][39:32]);
            chk({tag_of(VEC[i][47:40]), " pc"}, 32'(pc), 32'(VEC[i][31:16]));
            chk({tag_of(VEC[i][47:40]), " sp"}, 32'(sp), 32'(VEC[i][15:0]));
            if (VEC[i][15:0] == 16'h02FE) begin
                chk("R4 ret lo", 32'(mem[10'h2FE]), 32'h02);
                chk("R4 ret hi", 32'(mem[10'h2FF]), 32'h01);
            end
            if (VEC[i][31:16] == 16'h0100)
                chk("R5 no request when not taken", 32'(n_txn - t0), 32'd0);
        end

        // R6 restart 5
        do_reset();
        run_op(8'hEF, 8'h00);
        chk("R6 pc", 32'(pc), 32'h0028);
        chk("R6 sp", 32'(sp), 32'h02FE);
        chk("R6 stacked", {16'd0, mem[10'h2FF], mem[10'h2FE]}, 32'h0100);

        // R7 PCHL
        do_reset();
        hl_in = 16'hBEEF;
        run_op(8'hE9, 8'h00);
        chk("R7 pchl pc", 32'(pc), 32'hBEEF);

        // R7 XTHL
        do_reset();
        poke(16'h0300, 8'h34); poke(16'h0301, 8'h12);
        hl_in = 16'hABCD;
        @(negedge clk);
        run_op(8'hE3, 8'h00);
        chk("R7 xthl hl_we", 32'(hl_we), 32'd1);
        chk("R7 xthl hl", 32'(hl_wdata), 32'h1234);
        chk("R7 xthl sp", 32'(sp), 32'h0300);
        chk("R7 xthl stack", {16'd0, mem[10'h301], mem[10'h300]}, 32'hABCD);

        // R9 flag word push then pop; R8 byte order
        do_reset();
        acc_in = 8'h5A;
        run_op(8'hF5, 8'hC3);
        chk("R8 push sp", 32'(sp), 32'h02FE);
        chk("R9 push bytes", {16'd0, mem[10'h2FF], mem[10'h2FE]}, 32'h5AC3);
        @(negedge clk);
        run_op(8'hF1, 8'h00);
        chk("R9 pop strobes", {29'd0, acc_we, flag_lo_we, flag_all_we}, 32'b110);
        chk("R9 pop acc", 32'(acc_wdata), 32'h5A);
        chk("R9 pop flags", 32'(flag_wdata[7:0]), 32'hC3);
        chk("R8 pop sp", 32'(sp), 32'h0300);
        @(negedge clk);
        chk("R14 done one cycle", 32'(done), 32'd0);

        // R10 halt
        do_reset();
        run_op(8'h76, 8'h00);
        chk("R10 halted low at done", 32'(halted), 32'd0);
        @(negedge clk);
        chk("R10 halted", 32'(halted), 32'd1);
        t0 = n_txn;
        opcode = 8'hC3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 start ignored pc", 32'(pc), 32'h0100);
        chk("R10 no request", 32'(n_txn - t0), 32'd0);
        chk("R10 still halted", 32'(halted), 32'd1);
        irq = 1'b1;
        @(negedge clk); irq = 1'b0;
        chk("R10 irq wakes", 32'(halted), 32'd0);

        // R11 software interrupt
        do_reset();
        poke(16'h0100, 8'hED); poke(16'h0101, 8'h42);
        @(negedge clk);
        run_op(8'hED, 8'h00);
        chk("R11 swi_req", 32'(swi_req), 32'd1);
        chk("R11 vec", 32'(swi_vec), 32'h42);
        chk("R11 pc", 32'(pc), 32'h0102);
        chk("R11 sp", 32'(sp), 32'h0300);

        // R12 native exit
        do_reset();
        poke(16'h0100, 8'hFD);
        poke(16'h0300, 8'h11); poke(16'h0301, 8'h22);
        poke(16'h0302, 8'h33); poke(16'h0303, 8'h44);
        poke(16'h0304, 8'h55); poke(16'h0305, 8'h66);
        @(negedge clk);
        run_op(8'hED, 8'h00);
        chk("R12 pc", 32'(pc), 32'h2211);
        chk("R12 seg", 32'(seg_out), 32'h4433);
        chk("R12 flags", 32'(flag_wdata), 32'h6655);
        chk("R12 strobe/native", {30'd0, flag_all_we, native_mode}, 32'b11);
        chk("R12 sp", 32'(sp), 32'h0306);

        // R13 escape call
        do_reset();
        poke(16'h0100, 8'h78); poke(16'h0101, 8'h56);
        @(negedge clk);
        run_op(8'hED, 8'h00);
        chk("R13 pc", 32'(pc), 32'h5678);
        chk("R13 sp", 32'(sp), 32'h02FE);
        chk("R13 ret", {16'd0, mem[10'h2FF], mem[10'h2FE]}, 32'h0102);

        // R14 non-control opcode
        do_reset();
        t0 = n_txn;
        run_op(8'h80, 8'hFF);
        chk("R14 pc kept", 32'(pc), 32'h0100);
        chk("R14 sp kept", 32'(sp), 32'h0300);
        chk("R14 no request", 32'(n_txn - t0), 32'd0);
        @(negedge clk);
        chk("R14 idle after", {30'd0, busy, done}, 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule